// File: doc/BRIEF.md
# Early-Carry-Select Square-Root Adder

This block is a purely combinational binary adder. It adds two N-bit operands and a carry-in, and it returns an N-bit sum and a carry-out. The lowest bits are added by a short ripple section. The remaining bits are split into carry-select stages that grow by one bit each, counting upward from the least significant end. The carry-out of each section feeds the carry-in of the section above it. With the default width of 16, the partition is a 2-bit ripple head followed by stages of 2, 3, 4 and 5 bits.

Each stage first forms a per-bit XOR word and a per-bit AND word. From these it builds two complete carry words, one that assumes an incoming carry of 0 and one that assumes an incoming carry of 1. It then picks the final carry word using the real incoming carry. The sum comes last, from the XOR word and the chosen carries. The carry-1 word always covers the carry-0 word bit for bit. Because of this, the pick needs one AND-OR gate per bit and no multiplexer.

The block is meant to sit inside a datapath, for example as the accumulate adder of a multiply-accumulate unit. Its carry-out is available early because the selection happens before the sum XORs.

Top module: `csel_sqrt_adder`

## Requirements
- R1: For every a, b and cin, {cout, sum} equals a + b + cin as an unsigned N+1-bit value.
- R2: Bits [1:0] are formed by a 2-bit ripple head driven by cin. Its carry enters bit 2, and all 16 operand pairs with both cin values give the correct low sum and carry.
- R3: Bits above the head are built by early-carry-select stages at bits [3:2], [6:4], [10:7] and [15:11]. Each stage gives the correct field and carry-out for every operand pair of that field, with either incoming carry.
- R4: Inside each stage, every bit that is set in the carry-0 word is also set in the carry-1 word. The selected carry bit is the carry-0 bit OR'ed with the AND of the incoming carry and the carry-1 bit.
- R5: With a and b held, raising cin from 0 to 1 raises {cout, sum} by exactly one.
- R6: 0xFFFF + 0x0000 with cin = 1 gives sum 0x0000 and cout 1, so the carry runs through every stage.
- R7: 0x0000 + 0x0000 with cin = 0 gives sum 0x0000 and cout 0.
- R8: A stage accepts any width from 2 to 8 bits. An 8-bit stage used on its own obeys R1 for its own width, and a width outside 2 to 8, or a partition that does not cover N exactly, is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
Every result is combinational, so it is due in the same cycle as the operands that produce it, with no register in between. The bench changes the operands on the falling clock edge and compares them with its integer model 2 ns later, well before the next rising edge. Each check therefore sees settled logic from exactly one stimulus. The stage sweeps put a chosen carry into a stage through all-ones lower bits, so each stage sees both incoming carries while its own field is swept.

// File: rtl/csel_pkg.sv
package csel_pkg;

   // number of growing stages needed above the ripple head
   function automatic int stage_count(input int n, input int head_w, input int first_w);
      int used;
      int k;
      used = head_w;
      k    = 0;
      for (int i = 0; i < 64; i++) begin
         if (used < n) begin
            used = used + first_w + k;
            k    = k + 1;
         end
      end
      return k;
   endfunction

   // lowest bit of stage k
   function automatic int stage_offset(input int head_w, input int first_w, input int k);
      return head_w + k * first_w + (k * (k - 1)) / 2;
   endfunction

   // bits covered by head plus k stages
   function automatic int covered(input int head_w, input int first_w, input int k);
      return stage_offset(head_w, first_w, k);
   endfunction

endpackage

// File: rtl/csel_ripple_head.sv
module csel_ripple_head #(
   parameter int W = 2
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);

   logic [W:0] chain;

   assign chain[0] = ci;

   for (genvar i = 0; i < W; i++) begin : g_fa
      assign s[i]       = a[i] ^ b[i] ^ chain[i];
      assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
   end

   assign co = chain[W];

   initial begin
      a_r2_head_width : assert (W >= 1)
         else $error("ripple head width must be positive");
   end

   // R2: ripple head agrees with plain addition
   always_comb begin
      if (!$isunknown({a, b, ci})) begin
         a_r2_head_sum : assert ({co, s} == (W+1)'(a) + (W+1)'(b) + (W+1)'(ci))
            else $error("ripple head sum mismatch");
      end
   end

endmodule

// File: rtl/csel_early_stage.sv
module csel_early_stage #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);

   logic [W-1:0] hs;    // half-sum word
   logic [W-1:0] hc;    // half-carry word
   logic [W-1:0] cz;    // full carry assuming incoming 0
   logic [W-1:0] co1;   // full carry assuming incoming 1
   logic [W-1:0] csel;  // chosen carry word

   assign hs = a ^ b;
   assign hc = a & b;

   assign cz[0]  = hc[0];
   assign co1[0] = hc[0] | hs[0];

   for (genvar i = 1; i < W; i++) begin : g_carry
      assign cz[i]  = hc[i] | (hs[i] & cz[i-1]);
      assign co1[i] = hc[i] | (hs[i] & co1[i-1]);
   end

   // ordered carry words allow an AND-OR pick per bit
   assign csel = cz | ({W{ci}} & co1);

   assign co   = csel[W-1];
   assign s[0] = hs[0] ^ ci;

   for (genvar i = 1; i < W; i++) begin : g_sum
      assign s[i] = hs[i] ^ csel[i-1];
   end

   initial begin
      a_r8_stage_width : assert (W >= 2 && W <= 8)
         else $error("stage width must lie in 2..8");
   end

   always_comb begin
      if (!$isunknown({a, b, ci})) begin
         // R4: carry-1 word covers carry-0 word
         a_r4_carry_order : assert ((cz & ~co1) == '0)
            else $error("carry words out of order");
         // R3: stage result equals plain addition
         a_r3_stage_sum : assert ({co, s} == (W+1)'(a) + (W+1)'(b) + (W+1)'(ci))
            else $error("stage sum mismatch");
      end
   end

endmodule

// File: rtl/csel_sqrt_adder.sv
module csel_sqrt_adder #(
   parameter int N       = 16,
   parameter int HEAD_W  = 2,
   parameter int FIRST_W = 2
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cin,
   output logic [N-1:0] sum,
   output logic         cout
);

   localparam int NSTG = csel_pkg::stage_count(N, HEAD_W, FIRST_W);

   logic [NSTG:0] cy;

   csel_ripple_head #(.W(HEAD_W)) u_head (
      .a  (a[HEAD_W-1:0]),
      .b  (b[HEAD_W-1:0]),
      .ci (cin),
      .s  (sum[HEAD_W-1:0]),
      .co (cy[0])
   );

   for (genvar k = 0; k < NSTG; k++) begin : g_stage
      localparam int OFF = csel_pkg::stage_offset(HEAD_W, FIRST_W, k);
      localparam int SW  = FIRST_W + k;
      csel_early_stage #(.W(SW)) u_stg (
         .a  (a[OFF+SW-1:OFF]),
         .b  (b[OFF+SW-1:OFF]),
         .ci (cy[k]),
         .s  (sum[OFF+SW-1:OFF]),
         .co (cy[k+1])
      );
   end

   assign cout = cy[NSTG];

   initial begin
      a_r8_partition_exact : assert (csel_pkg::covered(HEAD_W, FIRST_W, NSTG) == N)
         else $error("stage partition does not cover N bits");
   end

   // R1: whole adder agrees with plain addition
   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         a_r1_total_sum : assert ({cout, sum} == (N+1)'(a) + (N+1)'(b) + (N+1)'(cin))
            else $error("adder sum mismatch");
      end
   end

endmodule

// File: tb/sim_csel_sqrt_adder.sv
module sim_csel_sqrt_adder;

   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n;
   always #4 clk = ~clk;   // 125 MHz

   logic [N-1:0] a, b, sum;
   logic         cin, cout;

   logic [7:0] a8, b8, s8;
   logic       ci8, co8;

   int checks = 0;
   int fails  = 0;

   csel_sqrt_adder u0 (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));
   csel_early_stage #(.W(8)) u1 (.a(a8), .b(b8), .ci(ci8), .s(s8), .co(co8));

   task automatic check(input string req, input logic [N:0] got, input logic [N:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   // reference: integer addition of the operands
   task automatic apply(input string req, input int x, input int y, input int c);
      int ref_v;
      @(negedge clk);
      a   = N'(x);
      b   = N'(y);
      cin = c[0];
      ref_v = (x & 32'hFFFF) + (y & 32'hFFFF) + (c & 1);
      #2;
      check(req, {cout, sum}, (N+1)'(ref_v));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int offs [4];
      int wids [4];
      offs = '{2, 4, 7, 11};
      wids = '{2, 3, 4, 5};
      rst_n = 1'b0;
      a = '0; b = '0; cin = 1'b0;
      a8 = '0; b8 = '0; ci8 = 1'b0;
      repeat (2) @(posedge clk);
      // R7: zeros during reset
      apply("R7 zero plus zero", 0, 0, 0);
      rst_n = 1'b1;

      // R6: full carry propagation
      apply("R6 all ones plus one", 32'hFFFF, 0, 1);
      apply("R6 all ones plus one via b", 32'hFFFF, 1, 0);
      apply("R1 max plus max", 32'hFFFF, 32'hFFFF, 1);

      // R2: ripple head exhaustive
      for (int x = 0; x < 4; x++)
         for (int y = 0; y < 4; y++)
            for (int c = 0; c < 2; c++)
               apply("R2 head", x, y, c);

      // R3/R4: each stage exhaustive with both incoming carries
      for (int k = 0; k < 4; k++)
         for (int x = 0; x < (1 << wids[k]); x++)
            for (int y = 0; y < (1 << wids[k]); y++)
               for (int c = 0; c < 2; c++)
                  apply("R3 stage sweep", (x << offs[k]) | (c != 0 ? ((1 << offs[k]) - 1) : 0),
                        (y << offs[k]) | c, 0);

      // R5: cin adds exactly one
      for (int i = 0; i < 200; i++) begin
         logic [N:0] lo;
         int x, y;
         x = int'($urandom_range(0, 65535));
         y = int'($urandom_range(0, 65535));
         apply("R5 cin low", x, y, 0);
         lo = {cout, sum};
         apply("R5 cin high", x, y, 1);
         check("R5 step of one", {cout, sum} - lo, (N+1)'(1));
      end

      // R1: random vectors
      for (int i = 0; i < 100000; i++)
         apply("R1 random", int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
               int'($urandom_range(0, 1)));

      // R8: widest stage used on its own
      for (int i = 0; i < 2000; i++) begin
         int x, y, c;
         x = int'($urandom_range(0, 255));
         y = int'($urandom_range(0, 255));
         c = int'($urandom_range(0, 1));
         @(negedge clk);
         a8 = 8'(x); b8 = 8'(y); ci8 = c[0];
         #2;
         check("R8 eight-bit stage", (N+1)'({co8, s8}), (N+1)'(x + y + c));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule